// File: doc/BRIEF.md
# Multichannel Frame Capture and Streamer

This block takes one frame of parallel audio samples on every sample strobe. It sends each new frame out, one word at a time, to a downstream stream FIFO. On a strobe, the capture side latches the whole sample bus into a holding register. It then writes the channels into one half of a two-bank memory, one channel per cycle. When the last channel has been written, it advances an 8-bit frame sequence number. The capture side never waits on the output.

The streaming side compares the sequence number with the last value it handled. When the two differ, it reads the bank that the sequence number's least significant bit selects. It then offers the channels, lowest first, on a valid/ready interface, and flags the first word of each frame. Because the comparison gates every transfer, a frame is never sent twice.

Frames that cannot be kept are counted in a saturating skip counter and set a sticky overflow flag. This covers three cases: a frame that completes while another is still streaming, a strobe that arrives while capture is busy, and a strobe whose target bank is being read. The flag stays set until the clear input is pulsed.

Top module: `frame_capture_streamer`

## Requirements
- R1: After reset, out_valid, ovf_flag and skip_count are all 0, and no word is offered until a strobe has been accepted.
- R2: A frame carries NUM_CH words. Word k is the sample at bus bits [k*SMP_W +: SMP_W], as sampled at the clock edge where the strobe was accepted. Words leave in ascending channel order, starting with channel 0.
- R3: out_sof is 1 on the channel-0 word of a frame and 0 on every other word.
- R4: Every accepted frame that is not skipped is offered exactly once. Nothing is offered when no new frame has completed.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_sof hold their values on the next cycle.
- R6: A strobe at any of the NUM_CH clock edges after an accepted strobe is dropped. The drop adds 1 to skip_count and sets ovf_flag.
- R7: A frame that completes while an earlier frame is still streaming, other than in the cycle of that frame's final word transfer, is never offered. It adds 1 to skip_count and sets ovf_flag.
- R8: While a frame is streaming, a strobe is refused if its frame would be written into the bank being read. The refusal adds 1 to skip_count and sets ovf_flag.
- R9: ovf_flag stays 1 until ovf_clear is high at a clock edge. That edge also zeroes skip_count. A loss at that same edge leaves ovf_flag at 1 and skip_count at 1.
- R10: skip_count saturates at its all-ones value (255 by default).
- R11: With out_ready held at 1, out_valid first rises at the (NUM_CH+3)-th rising edge after the edge where the strobe was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | One-cycle pulse: a new frame is on smp_bus |
| smp_bus | input | NUM_CH*SMP_W | All channel samples, channel k in bits [k*SMP_W +: SMP_W] |
| ovf_clear | input | 1 | Clears ovf_flag and skip_count |
| out_ready | input | 1 | Downstream FIFO can accept a word |
| out_valid | output | 1 | out_data/out_sof hold a word |
| out_data | output | SMP_W | Sample word |
| out_sof | output | 1 | First word (channel 0) of a frame |
| ovf_flag | output | 1 | Sticky lost-data flag |
| skip_count | output | SKIP_W | Saturating count of lost frames |

## Verification
The assertions check on every cycle four things. Offered words stay stable under backpressure. The capture bank never meets the bank being streamed. The overflow flag is sticky, and a clear zeroes the counter. The counter holds at saturation. The bench's directed scenarios show the rest: the first-word latency, word order and content, and the start-of-frame marking. They also show the three ways a frame can be lost. One is a frame that completes under a stalled stream, which the bench proves is never sent. Another is a strobe while capture is still writing. The third is a strobe aimed at the bank in use. Every handshake is compared with the bench's queue of expected words.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int FCS_CHANNELS = 20;
  localparam int FCS_SAMPLE_W = 16;
  localparam int FCS_SEQ_W    = 8;
  localparam int FCS_SKIP_W   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_OFFER = 2'd3
  } stream_state_t;
endpackage

// File: rtl/fcs_frame_ram.sv
module fcs_frame_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // simple dual port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fcs_capture.sv
module fcs_capture #(
  parameter int NUM_CH = 20,
  parameter int SMP_W  = 16,
  parameter int SEQ_W  = 8,
  parameter int CH_AW  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic [NUM_CH*SMP_W-1:0] bus,
  input  logic                    stream_busy,
  input  logic                    stream_bank,
  output logic                    wr_en,
  output logic [CH_AW:0]          wr_addr,
  output logic [SMP_W-1:0]        wr_data,
  output logic [SEQ_W-1:0]        seq,
  output logic                    commit,
  output logic                    refused
);
  localparam logic [CH_AW-1:0] LAST_IDX = CH_AW'(NUM_CH - 1);

  logic [SMP_W-1:0] hold_q [NUM_CH];
  logic             active_q;
  logic [CH_AW-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;
  logic             target_bank;
  logic             accept;

  // the next frame number's LSB picks the bank
  assign target_bank = ~seq_q[0];
  assign accept  = strobe && !active_q && !(stream_busy && (stream_bank == target_bank));
  assign refused = strobe && !accept;

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int c = 0; c < NUM_CH; c++) hold_q[c] <= bus[c*SMP_W +: SMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      seq_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        seq_q    <= seq_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign wr_en   = active_q;
  assign wr_addr = {target_bank, idx_q};
  assign wr_data = hold_q[idx_q];
  assign commit  = active_q && (idx_q == LAST_IDX);
  assign seq     = seq_q;
endmodule

// File: rtl/fcs_streamer.sv
module fcs_streamer
  import fcs_pkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int SMP_W  = 16,
  parameter int SEQ_W  = 8,
  parameter int CH_AW  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] seq_in,
  output logic [CH_AW:0]   rd_addr,
  input  logic [SMP_W-1:0] rd_data,
  output logic             busy,
  output logic             bank,
  output logic             done_now,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data,
  output logic             out_sof
);
  localparam logic [CH_AW-1:0] LAST_IDX = CH_AW'(NUM_CH - 1);

  stream_state_t    state_q;
  logic [SEQ_W-1:0] seen_q;
  logic [CH_AW-1:0] ch_q;
  logic             bank_q;
  logic             valid_q;
  logic [SMP_W-1:0] data_q;
  logic             sof_q;

  assign rd_addr  = {bank_q, ch_q};
  assign busy     = (state_q != ST_IDLE);
  assign bank     = bank_q;
  assign done_now = (state_q == ST_OFFER) && out_ready && (ch_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seen_q  <= '0;
      ch_q    <= '0;
      bank_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      sof_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (seq_in != seen_q) begin
            seen_q  <= seq_in;
            bank_q  <= seq_in[0];
            ch_q    <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          data_q  <= rd_data;
          sof_q   <= (ch_q == '0);
          valid_q <= 1'b1;
          state_q <= ST_OFFER;
        end
        ST_OFFER: begin
          if (out_ready) begin
            valid_q <= 1'b0;
            if (ch_q == LAST_IDX) begin
              // absorb frames that completed mid-stream
              seen_q  <= seq_in;
              state_q <= ST_IDLE;
            end else begin
              ch_q    <= ch_q + 1'b1;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_sof   = sof_q;

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));
endmodule

// File: rtl/fcs_loss_track.sv
module fcs_loss_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             loss_a,
  input  logic             loss_b,
  output logic             flag,
  output logic [CNT_W-1:0] count
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'({CNT_W{1'b1}});

  logic             flag_q;
  logic [CNT_W-1:0] count_q;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic             any_loss;

  always_comb begin
    any_loss = loss_a | loss_b;
    base     = clear ? '0 : SUM_W'(count_q);
    sum      = base + SUM_W'(loss_a) + SUM_W'(loss_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      count_q <= '0;
    end else begin
      flag_q  <= (clear ? 1'b0 : flag_q) | any_loss;
      count_q <= (sum > MAX_SUM) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  assign flag  = flag_q;
  assign count = count_q;

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clear) |=> flag);
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    (clear && !loss_a && !loss_b) |=> (!flag && count == '0));
  a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == {CNT_W{1'b1}} && !clear) |=> (count == {CNT_W{1'b1}}));
endmodule

// File: rtl/frame_capture_streamer.sv
module frame_capture_streamer
  import fcs_pkg::*;
#(
  parameter int NUM_CH = FCS_CHANNELS,
  parameter int SMP_W  = FCS_SAMPLE_W,
  parameter int SEQ_W  = FCS_SEQ_W,
  parameter int SKIP_W = FCS_SKIP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_strobe,
  input  logic [NUM_CH*SMP_W-1:0] smp_bus,
  input  logic                    ovf_clear,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [SMP_W-1:0]        out_data,
  output logic                    out_sof,
  output logic                    ovf_flag,
  output logic [SKIP_W-1:0]       skip_count
);
  localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int RAM_AW = CH_AW + 1;

  logic              cap_we;
  logic [RAM_AW-1:0] cap_addr;
  logic [SMP_W-1:0]  cap_data;
  logic [SEQ_W-1:0]  frame_seq;
  logic              cap_commit;
  logic              cap_refused;
  logic [RAM_AW-1:0] rd_addr;
  logic [SMP_W-1:0]  rd_data;
  logic              st_busy;
  logic              st_bank;
  logic              st_done;
  logic              late_commit;

  fcs_capture #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .SEQ_W(SEQ_W), .CH_AW(CH_AW)) u_capture (
    .clk(clk), .rst(rst), .strobe(smp_strobe), .bus(smp_bus),
    .stream_busy(st_busy), .stream_bank(st_bank),
    .wr_en(cap_we), .wr_addr(cap_addr), .wr_data(cap_data),
    .seq(frame_seq), .commit(cap_commit), .refused(cap_refused)
  );

  fcs_frame_ram #(.DATA_W(SMP_W), .ADDR_W(RAM_AW)) u_ram (
    .clk(clk), .wr_en(cap_we), .wr_addr(cap_addr), .wr_data(cap_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fcs_streamer #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .SEQ_W(SEQ_W), .CH_AW(CH_AW)) u_stream (
    .clk(clk), .rst(rst), .seq_in(frame_seq), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(st_busy), .bank(st_bank), .done_now(st_done),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof)
  );

  // a frame finishing while another is mid-stream is absorbed unsent
  assign late_commit = cap_commit && st_busy && !st_done;

  fcs_loss_track #(.CNT_W(SKIP_W)) u_loss (
    .clk(clk), .rst(rst), .clear(ovf_clear),
    .loss_a(cap_refused), .loss_b(late_commit),
    .flag(ovf_flag), .count(skip_count)
  );

  a_r8_bank_apart: assert property (@(posedge clk) disable iff (rst)
    (cap_we && st_busy) |-> (cap_addr[RAM_AW-1] != st_bank));
endmodule

// File: tb/sim_frame_capture_streamer.sv
module sim_frame_capture_streamer;
  localparam int NCH = 20;
  localparam int SW  = 16;
  localparam int KW  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              smp_strobe = 1'b0;
  logic [NCH*SW-1:0] smp_bus = '0;
  logic              ovf_clear = 1'b0;
  logic              out_ready = 1'b1;
  logic              out_valid;
  logic [SW-1:0]     out_data;
  logic              out_sof;
  logic              ovf_flag;
  logic [KW-1:0]     skip_count;

  frame_capture_streamer u0 (
    .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .smp_bus(smp_bus),
    .ovf_clear(ovf_clear), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .ovf_flag(ovf_flag), .skip_count(skip_count)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ready_mode = 0; // 0 high, 1 low, 2 random
  logic [SW:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] word_of(input int seed, input int ch);
    return SW'((seed * 97 + ch * 11 + 5) & 16'hFFFF);
  endfunction

  function automatic logic [NCH*SW-1:0] bus_of(input int seed);
    logic [NCH*SW-1:0] b;
    for (int c = 0; c < NCH; c++) b[c*SW +: SW] = word_of(seed, c);
    return b;
  endfunction

  task automatic expect_frame(input int seed);
    for (int c = 0; c < NCH; c++) expq.push_back({c == 0, word_of(seed, c)});
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    #1;
    if (ready_mode == 0) out_ready = 1'b1;
    else if (ready_mode == 1) out_ready = 1'b0;
    else out_ready = 1'($urandom % 2);
  end

  // reference model: queue of expected words, checked on every clock
  bit prev_stall = 0;
  logic [SW-1:0] prev_data;
  logic prev_sof;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data && out_sof == prev_sof, "R5",
            "stalled word changed", longint'(out_data), longint'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_sof   = out_sof;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4", "unexpected word", longint'(out_data), -1);
        end else begin
          logic [SW:0] e;
          e = expq.pop_front();
          chk(out_data == e[SW-1:0], "R2", "word value", longint'(out_data), longint'(e[SW-1:0]));
          chk(out_sof == e[SW], "R3", "sof marker", longint'(out_sof), longint'(e[SW]));
        end
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "WATCHDOG", "run hung", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) step();
    rst = 1'b0;
    step();
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid after reset", out_valid, 0);
    chk(ovf_flag == 0, "R1", "flag after reset", ovf_flag, 0);
    chk(skip_count == 0, "R1", "skip after reset", skip_count, 0);
    repeat (50) step(); // R1: monitor flags any word with no frame

    // R11 latency and R2/R3 single frame
    smp_bus = bus_of(1); smp_strobe = 1'b1; expect_frame(1);
    @(posedge clk); #1; smp_strobe = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (out_valid) break;
    end
    chk(n == NCH + 3, "R11", "first word latency", n, NCH + 3);
    repeat (200) step();
    chk(expq.size() == 0, "R4", "frame drained once", expq.size(), 0);
    chk(skip_count == 0, "R4", "no loss in clean run", skip_count, 0);

    // R5 random backpressure, several frames
    ready_mode = 2;
    for (int f = 2; f < 8; f++) begin
      smp_bus = bus_of(f); smp_strobe = 1'b1; expect_frame(f);
      step(); smp_strobe = 1'b0;
      repeat (400) step();
    end
    ready_mode = 0;
    repeat (20) step();
    chk(expq.size() == 0, "R5", "frames drained under backpressure", expq.size(), 0);

    // R6 strobe during capture
    smp_bus = bus_of(20); smp_strobe = 1'b1; expect_frame(20);
    step(); smp_strobe = 1'b0;
    repeat (4) step();
    smp_bus = bus_of(21); smp_strobe = 1'b1;
    step(); smp_strobe = 1'b0;
    repeat (200) step();
    chk(skip_count == 1, "R6", "skip after busy strobe", skip_count, 1);
    chk(ovf_flag == 1, "R6", "flag after busy strobe", ovf_flag, 1);

    // R9 clear, then sticky flag still clear-able
    repeat (10) step();
    chk(ovf_flag == 1, "R9", "flag sticky", ovf_flag, 1);
    ovf_clear = 1'b1; step(); ovf_clear = 1'b0; step();
    chk(ovf_flag == 0 && skip_count == 0, "R9", "clear zeroes", skip_count, 0);
    // R9 loss at the same edge as clear
    smp_bus = bus_of(30); smp_strobe = 1'b1; expect_frame(30);
    step();
    ovf_clear = 1'b1;
    step();
    ovf_clear = 1'b0; smp_strobe = 1'b0;
    step();
    chk(ovf_flag == 1, "R9", "flag with simultaneous loss", ovf_flag, 1);
    chk(skip_count == 1, "R9", "count with simultaneous loss", skip_count, 1);
    repeat (200) step();
    ovf_clear = 1'b1; step(); ovf_clear = 1'b0; step();

    // R7 and R8 with a stalled stream
    ready_mode = 1;
    smp_bus = bus_of(40); smp_strobe = 1'b1; expect_frame(40);
    step(); smp_strobe = 1'b0;
    repeat (40) step();
    smp_bus = bus_of(41); smp_strobe = 1'b1; // completes mid-stream
    step(); smp_strobe = 1'b0;
    repeat (40) step();
    chk(skip_count == 1, "R7", "late frame counted", skip_count, 1);
    smp_bus = bus_of(42); smp_strobe = 1'b1; // bank in use
    step(); smp_strobe = 1'b0;
    repeat (5) step();
    chk(skip_count == 2, "R8", "clash strobe refused", skip_count, 2);
    chk(ovf_flag == 1, "R8", "flag after clash", ovf_flag, 1);
    ready_mode = 0;
    repeat (150) step();
    chk(expq.size() == 0, "R7", "only earlier frame sent", expq.size(), 0);
    smp_bus = bus_of(43); smp_strobe = 1'b1; expect_frame(43);
    step(); smp_strobe = 1'b0;
    repeat (150) step();
    chk(expq.size() == 0, "R8", "next frame after clash sent", expq.size(), 0);

    // R10 saturation
    ovf_clear = 1'b1; step(); ovf_clear = 1'b0; step();
    for (int p = 0; p < 256; p++) begin
      smp_bus = bus_of(100 + p); smp_strobe = 1'b1; expect_frame(100 + p);
      step(); step();
      smp_strobe = 1'b0;
      repeat (118) step();
      if (p == 254) chk(skip_count == 255, "R10", "count reaches max", skip_count, 255);
    end
    chk(skip_count == 255, "R10", "count holds at max", skip_count, 255);
    chk(expq.size() == 0, "R4", "all kept frames sent", expq.size(), 0);
    ovf_clear = 1'b1; step(); ovf_clear = 1'b0; step();
    chk(skip_count == 0 && ovf_flag == 0, "R9", "final clear", skip_count, 0);

    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule